// File: doc/BRIEF.md
# Sign-Agreement Extrinsic Scaling Unit

This unit sits between the constituent soft-output decoders of an iterative turbo-style decoder. For every half-iteration it takes in one frame of signed log-likelihood pairs: an extrinsic value and an a-posteriori value for each position. It counts the positions at which the two values carry the same sign and divides that count by the frame length. The result is a fixed-point ratio between 0 and 1.

The extrinsic values are held in a local frame buffer while the ratio is formed. They are then streamed out again, each multiplied by the ratio, so that the next decoder gets damped extrinsic information. The same ratio is compared with a programmable threshold. Together with a half-iteration counter, it decides whether the decoder should stop iterating. At the end of every half-iteration a one-cycle completion pulse is raised, and the stop flag is valid with it.

The controller has three states. `ST_COLLECT` accepts inputs. A frame end (last marker, or a full buffer) moves it to `ST_DIVIDE`. Completion of the divider moves it to `ST_EMIT`. Emission of the final scaled value returns it to `ST_COLLECT`.

Top module: `agree_scale_unit`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid`, `out_last`, `done` and `stop` are 0.
- R2: A position agrees when the most significant bits of `in_ext` and `in_app` are equal, so a zero value counts as non-negative.
- R3: The ratio is floor(A*256/L), where A is the number of agreeing positions and L is the number of positions in the frame; it is a 9-bit unsigned value with 8 fractional bits, produced by a sequential divider started at the frame end.
- R4: The scaled outputs appear in input order, one per cycle, each equal to in_ext*ratio/256 rounded toward zero and limited to the signed range of the input width; `out_last` marks the final one.
- R5: A frame ends at the accepted input with `in_last` = 1, or at the NMAX-th accepted input if no last marker came earlier.
- R6: `in_ready` is 0 from the cycle after the frame end until the completion pulse; inputs offered while it is 0 are ignored.
- R7: `stop` is 1 when the ratio is greater than or equal to `thr`.
- R8: `stop` is also 1 at the 24th consecutive half-iteration (2*MAX_ITER) since reset or the previous stop, whatever the threshold; the half-iteration count restarts after each stop.
- R9: `done` is a single-cycle pulse that coincides with the final scaled output, and `stop` is never 1 without `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pair offered |
| in_ready | output | 1 | Unit is collecting a frame |
| in_ext | input | W | Extrinsic value, two's complement |
| in_app | input | W | A-posteriori value, two's complement |
| in_last | input | 1 | Final position of the frame |
| thr | input | FRAC+1 | Stop threshold, same scale as the ratio |
| out_valid | output | 1 | Scaled value present |
| out_data | output | W | Scaled extrinsic value |
| out_last | output | 1 | Final scaled value of the frame |
| done | output | 1 | Half-iteration complete |
| stop | output | 1 | Early-stop decision, valid with done |

## Verification
The bench sweeps every frame length from 1 to the buffer depth with pseudo-random values that include the most negative code. It also ends one frame with no last marker. Each scaled value is compared with an arithmetic model. A wrong rounding direction would make negative products one step too large in magnitude, and a wrong divider would shift every output. Zero-valued inputs against negative partners check the sign rule. A design that treated zero as negative would miscount agreement. Thresholds exactly at and one step above the ratio (including a ratio of exactly 1.0) catch an off-by-one comparison. A long run with an unreachable threshold shows whether the iteration cap fires at exactly the 24th half-iteration and whether the count restarts. Junk offered while the unit is busy would corrupt the frame count if it were accepted.

// File: rtl/agree_pkg.sv
package agree_pkg;
    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_DIVIDE  = 2'd1,
        ST_EMIT    = 2'd2
    } phase_t;
endpackage

// File: rtl/ratio_divider.sv
module ratio_divider #(
    parameter int NW   = 5,
    parameter int FRAC = 8,
    parameter int QW   = FRAC + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] num,
    input  logic [NW-1:0] den,
    output logic          fin,
    output logic [QW-1:0] quo
);
    localparam int NB = NW + FRAC;
    localparam int SW = $clog2(NB + 1);

    logic [NB-1:0] dvd, q;
    logic [NW-1:0] rem, dsr;
    logic [SW-1:0] steps;
    logic          run;
    logic [NW:0]   trial;

    assign trial = {rem, dvd[NB-1]};
    assign quo   = q[QW-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd <= '0; q <= '0; rem <= '0; dsr <= '0;
            steps <= '0; run <= 1'b0; fin <= 1'b0;
        end else begin
            fin <= run && (steps == SW'(1));
            if (start) begin
                dvd   <= {num, {FRAC{1'b0}}};
                dsr   <= den;
                rem   <= '0;
                q     <= '0;
                steps <= SW'(NB);
                run   <= 1'b1;
            end else if (run) begin
                if (trial >= {1'b0, dsr}) begin
                    rem <= NW'(trial - {1'b0, dsr});
                    q   <= {q[NB-2:0], 1'b1};
                end else begin
                    rem <= trial[NW-1:0];
                    q   <= {q[NB-2:0], 1'b0};
                end
                dvd   <= dvd << 1;
                steps <= steps - SW'(1);
                if (steps == SW'(1)) run <= 1'b0;
            end
        end
    end

    // R3: a ratio never exceeds 1.0, so no quotient bit above QW is set
    p_ratio_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> ((q >> QW) == '0) && (quo <= QW'(1 << FRAC)));
endmodule

// File: rtl/scale_mult.sv
module scale_mult #(
    parameter int W    = 8,
    parameter int FRAC = 8
) (
    input  logic [W-1:0]  ext,
    input  logic [FRAC:0] ratio,
    output logic [W-1:0]  scaled
);
    localparam int PW = W + FRAC + 2;
    localparam logic signed [PW-1:0] RND  = PW'((1 << FRAC) - 1);
    localparam logic signed [PW-1:0] MAXV = PW'((1 << (W - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

    logic signed [PW-1:0] prod, biased, shf;

    always_comb begin
        prod   = $signed({{(PW - W){ext[W-1]}}, ext}) *
                 $signed({{(PW - FRAC - 1){1'b0}}, ratio});
        biased = prod[PW-1] ? prod + RND : prod;
        shf    = biased >>> FRAC;
        if (shf > MAXV)      scaled = MAXV[W-1:0];
        else if (shf < MINV) scaled = MINV[W-1:0];
        else                 scaled = shf[W-1:0];
    end
endmodule

// File: rtl/agree_scale_unit.sv
module agree_scale_unit
    import agree_pkg::*;
#(
    parameter int W        = 8,
    parameter int NMAX     = 16,
    parameter int FRAC     = 8,
    parameter int MAX_ITER = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [W-1:0]  in_ext,
    input  logic [W-1:0]  in_app,
    input  logic          in_last,
    input  logic [FRAC:0] thr,
    output logic          out_valid,
    output logic [W-1:0]  out_data,
    output logic          out_last,
    output logic          done,
    output logic          stop
);
    localparam int CW       = $clog2(NMAX + 1);
    localparam int AW       = $clog2(NMAX);
    localparam int QW       = FRAC + 1;
    localparam int HALF_CAP = 2 * MAX_ITER;
    localparam int HW       = $clog2(HALF_CAP + 1);

    phase_t        state, nxt;
    logic [W-1:0]  xbuf [NMAX];
    logic [CW-1:0] wr_cnt, agree, len;
    logic [AW-1:0] rd_idx;
    logic [QW-1:0] ratio, div_quo;
    logic [HW-1:0] half_cnt;
    logic          stop_pend, div_fin, accept, match, frame_end, emit_end;
    logic [W-1:0]  scaled;

    assign in_ready  = (state == ST_COLLECT);
    assign accept    = in_valid && in_ready;
    assign match     = (in_ext[W-1] == in_app[W-1]);
    assign frame_end = accept && (in_last || wr_cnt == CW'(NMAX - 1));
    assign emit_end  = (state == ST_EMIT) && (CW'(rd_idx) == len - CW'(1));

    ratio_divider #(.NW(CW), .FRAC(FRAC), .QW(QW)) u_div (
        .clk(clk), .rst_n(rst_n), .start(frame_end),
        .num(agree + CW'(match)), .den(wr_cnt + CW'(1)),
        .fin(div_fin), .quo(div_quo)
    );

    scale_mult #(.W(W), .FRAC(FRAC)) u_mul (
        .ext(xbuf[rd_idx]), .ratio(ratio), .scaled(scaled)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_COLLECT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_COLLECT: if (frame_end) nxt = ST_DIVIDE;
            ST_DIVIDE:  if (div_fin)   nxt = ST_EMIT;
            ST_EMIT:    if (emit_end)  nxt = ST_COLLECT;
            default:                   nxt = ST_COLLECT;
        endcase
    end

    // frame datapath
    always_ff @(posedge clk) begin
        if (accept) xbuf[wr_cnt[AW-1:0]] <= in_ext;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt <= '0; agree <= '0; len <= '0; rd_idx <= '0;
            ratio <= '0; stop_pend <= 1'b0; half_cnt <= '0;
        end else begin
            unique case (state)
                ST_COLLECT: if (accept) begin
                    wr_cnt <= wr_cnt + CW'(1);
                    agree  <= agree + CW'(match);
                    if (frame_end) len <= wr_cnt + CW'(1);
                end
                ST_DIVIDE: if (div_fin) begin
                    ratio     <= div_quo;
                    stop_pend <= (div_quo >= thr) || (half_cnt == HW'(HALF_CAP - 1));
                    rd_idx    <= '0;
                end
                ST_EMIT: begin
                    rd_idx <= rd_idx + AW'(1);
                    if (emit_end) begin
                        wr_cnt   <= '0;
                        agree    <= '0;
                        half_cnt <= stop_pend ? '0 : half_cnt + HW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0; out_data <= '0; out_last <= 1'b0;
            done <= 1'b0; stop <= 1'b0;
        end else begin
            out_valid <= (state == ST_EMIT);
            out_data  <= (state == ST_EMIT) ? scaled : '0;
            out_last  <= emit_end;
            done      <= emit_end;
            stop      <= emit_end && stop_pend;
        end
    end

    p_stop_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop |-> done);
    p_done_with_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> out_valid && out_last);
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_ready_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> done);
    p_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        half_cnt < HW'(HALF_CAP));
    p_zero_ratio_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ratio == '0) |-> (out_data == '0));
endmodule

// File: tb/sim_agree_scale_unit.sv
module sim_agree_scale_unit;
    localparam int W = 8, NMAX = 16, FRAC = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic [W-1:0] in_ext = '0, in_app = '0;
    logic [FRAC:0] thr = '1;
    logic in_ready, out_valid, out_last, done, stop;
    logic [W-1:0] out_data;

    always #4 clk = ~clk;

    agree_scale_unit #(.W(W), .NMAX(NMAX), .FRAC(FRAC), .MAX_ITER(12)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_ext(in_ext), .in_app(in_app), .in_last(in_last), .thr(thr),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .done(done), .stop(stop)
    );

    int errors = 0, checks = 0, exp_cnt = 0, seed = 7;
    int ve [NMAX], va [NMAX], got [NMAX];
    bit gotl [NMAX];
    int ocnt = 0, done_pos = 0;
    bit dseen = 0, sseen = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd8();
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 16) & 255) - 128;
    endfunction

    always @(negedge clk) begin
        if (out_valid) begin
            if (ocnt < NMAX) begin
                got[ocnt]  = int'($signed(out_data));
                gotl[ocnt] = out_last;
            end
            ocnt++;
        end
        if (done) begin
            dseen = 1; sseen = stop; done_pos = ocnt;
        end
    end

    task automatic run_frame(input int len, input bit use_last, input int thr_v, input bit junk);
        int a = 0, q, ex;
        bit exp_stop;
        for (int i = 0; i < len; i++) a += ((ve[i] < 0) == (va[i] < 0)) ? 1 : 0;  // R2 rule
        q = (a * 256) / len;                                                     // R3
        ocnt = 0; dseen = 0;
        thr = (FRAC+1)'(thr_v);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1; in_ext = W'(ve[i]); in_app = W'(va[i]);
            in_last = use_last && (i == len - 1);
        end
        @(negedge clk);
        chk(in_ready == 1'b0, "R6 busy after frame end", int'(in_ready), 0);
        if (junk) begin
            in_ext = 8'h55; in_app = 8'h55; in_last = 1;
            repeat (4) @(negedge clk);
        end
        in_valid = 0; in_last = 0;
        while (!dseen) @(posedge clk);
        for (int i = 0; i < len; i++) begin
            ex = (ve[i] * q) / 256;  // truncation toward zero
            chk(got[i] == ex, "R3 R4 scaled value", got[i], ex);
        end
        chk(ocnt == len, "R5 R6 output count", ocnt, len);
        chk(gotl[len-1] == 1'b1, "R4 last marker", int'(gotl[len-1]), 1);
        chk(done_pos == len, "R9 done with final output", done_pos, len);
        exp_stop = (q >= thr_v) || (exp_cnt == 23);
        if (q >= thr_v) chk(sseen == exp_stop, "R7 threshold stop", int'(sseen), int'(exp_stop));
        else            chk(sseen == exp_stop, "R8 iteration cap stop", int'(sseen), int'(exp_stop));
        exp_cnt = exp_stop ? 0 : exp_cnt + 1;
        @(negedge clk);
        chk(done == 1'b0, "R9 done single cycle", int'(done), 0);
        chk(in_ready == 1'b1, "R6 ready again", int'(in_ready), 1);
    endtask

    task automatic fill_rand(input int len);
        for (int i = 0; i < len; i++) begin ve[i] = rnd8(); va[i] = rnd8(); end
    endtask

    initial begin
        #(8 * 150000);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        chk(out_last == 1'b0, "R1 reset out_last", int'(out_last), 0);
        chk(done == 1'b0, "R1 reset done", int'(done), 0);
        chk(stop == 1'b0, "R1 reset stop", int'(stop), 0);

        // R2: zero against negative disagrees, zero against zero agrees
        ve[0] = 0; va[0] = -1; ve[1] = 0; va[1] = 0;
        ve[2] = 5; va[2] = 7;  ve[3] = -3; va[3] = -2;
        run_frame(4, 1, 511, 0);

        // R5 and R4: every length, plus a frame ended only by a full buffer
        for (int n = 1; n <= NMAX; n++) begin
            fill_rand(n);
            ve[0] = -128;
            run_frame(n, 1, 511, 0);
        end
        fill_rand(NMAX);
        run_frame(NMAX, 0, 511, 0);

        // R7: ratio 1.0 at and above threshold, ratio 0.5 at the boundary
        for (int i = 0; i < 8; i++) begin ve[i] = rnd8(); va[i] = (ve[i] < 0) ? -9 : 9; end
        run_frame(8, 1, 256, 0);
        run_frame(8, 1, 257, 0);
        ve[0] = 40; va[0] = 3; ve[1] = -77; va[1] = 12;
        run_frame(2, 1, 128, 0);
        run_frame(2, 1, 129, 0);
        // all positions disagree: ratio 0
        for (int i = 0; i < 6; i++) begin ve[i] = rnd8(); va[i] = (ve[i] < 0) ? 1 : -1; end
        run_frame(6, 1, 511, 0);

        // R6: inputs offered while busy are ignored
        fill_rand(10);
        run_frame(10, 1, 511, 1);
        fill_rand(5);
        run_frame(5, 1, 511, 0);

        // R8: unreachable threshold, cap must fire and restart
        for (int k = 0; k < 52; k++) begin
            fill_rand(8);
            run_frame(8, 1, 511, 0);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule